// File: doc/BRIEF.md
# Power-up reset release sequencer

This block turns one master power-on reset into a set of separate active-low reset lines that are let go in a fixed order. It runs on the 13 MHz timing clock. When the master reset is removed it first raises a clock-run strobe, which tells the clock generators they may start. It then counts a fixed interval before it frees the microcontroller and the radio interface together.

The signal-processor reset has its own release point. It is counted from the moment that processor's clock enable is seen, over a delay of 0 to 255 cycles taken from an 8-bit input. In the system that input is normally set to 255. The smart-card reset is held until the card clock has run for at least 400 card-clock periods. The card clock is a quarter of the timing clock, so this is 1600 timing-clock cycles.

Every reset line is pulled low at once, without waiting for a clock, when the master reset is asserted. Every line goes high only on a clock edge. Once a line has been released it stays released until the next master reset.

Top module: `rst_release_seq`

## Requirements
- R1: While `por_n` is low, every reset output and `clk_run_o` are low. Pulling `por_n` low at any moment drives all of them low at once, without waiting for a clock edge, and restarts every count.
- R2: Let e1 be the first rising `clk` edge after `por_n` rises. `clk_run_o` is still low after e1 and is high after e2.
- R3: `mcu_rst_n_o` and `rfi_rst_n_o` stay low through edge e257 and both go high at edge e258, which is 256 edges after `clk_run_o` rose.
- R4: Let k be the first rising edge at which `clk_run_o` is already high and `dsp_clk_en_i` is sampled high. With the delay N on `dsp_dly_i`, `dsp_rst_n_o` stays low before edge k+N and goes high at edge k+N. When N is 0, the release happens at edge k itself.
- R5: If `dsp_clk_en_i` falls before the signal-processor reset has been released, the count is discarded. The next high sample of `dsp_clk_en_i` becomes a new edge k.
- R6: Let c be the first rising edge at which `clk_run_o` is high and `card_clk_on_i` is sampled high. `card_rst_n_o` goes high at edge c+1599. If `card_clk_on_i` drops before that edge, the count restarts.
- R7: Once a reset output has gone high, it stays high while `por_n` stays high, even if `dsp_clk_en_i` or `card_clk_on_i` goes low.
- R8: The largest delay, N = 255 (the system's usual setting), releases `dsp_rst_n_o` at edge k+255 and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 13 MHz timing clock |
| por_n | input | 1 | Master power-on reset, active low, asynchronous |
| dsp_clk_en_i | input | 1 | Signal-processor clock is enabled |
| card_clk_on_i | input | 1 | Smart-card clock is running |
| dsp_dly_i | input | 8 | Signal-processor release delay in clk cycles, 0 to 255 |
| clk_run_o | output | 1 | Clock-start strobe, high once the master reset has been synchronously removed |
| mcu_rst_n_o | output | 1 | Microcontroller reset, active low |
| rfi_rst_n_o | output | 1 | Radio-interface reset, active low |
| dsp_rst_n_o | output | 1 | Signal-processor reset, active low |
| card_rst_n_o | output | 1 | Smart-card reset, active low |

## Verification
The assertions assume that `dsp_dly_i` stays steady while a signal-processor count is running, and that the enable inputs are single-clock-domain levels. Under those conditions a release happens only while the matching run condition holds, and a released line never drops while the master reset is high. The stimulus changes the enables and the delay only on falling clock edges. It loads a new delay only while the signal-processor reset is held, either in reset or with its enable low. It drops `por_n` partway through a cycle to exercise the immediate assertion of the resets.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  parameter int unsigned MCU_CYCLES_DEF  = 256;
  parameter int unsigned CARD_CYCLES_DEF = 400;
  parameter int unsigned CARD_DIV_DEF    = 4;
  parameter int unsigned DLY_W_DEF       = 8;
endpackage

// File: rtl/rrs_sync.sv
module rrs_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_s_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_s_n = sync_q;
endmodule

// File: rtl/rrs_delay_cnt.sv
module rrs_delay_cnt #(
  parameter int unsigned W           = 8,
  parameter bit          CLR_ON_IDLE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         done_q, done_d;
  logic [W-1:0] idle_cnt;

  generate
    if (CLR_ON_IDLE) begin : g_restart
      assign idle_cnt = '0;
    end else begin : g_hold
      assign idle_cnt = cnt_q;
    end
  endgenerate

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (!done_q) begin
      if (run) begin
        if (cnt_q == limit) begin
          done_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        cnt_d = idle_cnt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;

  // R7: a released line stays released
  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R5: release only on an edge where the run condition was sampled
  assert_release_needs_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(run));
endmodule

// File: rtl/rst_release_seq.sv
module rst_release_seq
  import rrs_pkg::*;
#(
  parameter int unsigned MCU_CYCLES  = MCU_CYCLES_DEF,
  parameter int unsigned CARD_CYCLES = CARD_CYCLES_DEF,
  parameter int unsigned CARD_DIV    = CARD_DIV_DEF,
  parameter int unsigned DLY_W       = DLY_W_DEF
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             dsp_clk_en_i,
  input  logic             card_clk_on_i,
  input  logic [DLY_W-1:0] dsp_dly_i,
  output logic             clk_run_o,
  output logic             mcu_rst_n_o,
  output logic             rfi_rst_n_o,
  output logic             dsp_rst_n_o,
  output logic             card_rst_n_o
);
  localparam int unsigned MCU_W     = (MCU_CYCLES > 1) ? $clog2(MCU_CYCLES) : 1;
  localparam int unsigned CARD_TOT  = CARD_CYCLES * CARD_DIV;
  localparam int unsigned CARD_W    = (CARD_TOT > 1) ? $clog2(CARD_TOT) : 1;
  localparam logic [MCU_W-1:0]  MCU_LIM  = MCU_W'(MCU_CYCLES - 1);
  localparam logic [CARD_W-1:0] CARD_LIM = CARD_W'(CARD_TOT - 1);

  logic rst_s_n;
  logic mcu_done, dsp_done, card_done;

  rrs_sync u_sync (
    .clk     (clk),
    .arst_n  (por_n),
    .rst_s_n (rst_s_n)
  );

  rrs_delay_cnt #(.W(MCU_W), .CLR_ON_IDLE(1'b0)) u_mcu_cnt (
    .clk   (clk),
    .rst_n (rst_s_n),
    .run   (1'b1),
    .limit (MCU_LIM),
    .done  (mcu_done)
  );

  rrs_delay_cnt #(.W(DLY_W), .CLR_ON_IDLE(1'b1)) u_dsp_cnt (
    .clk   (clk),
    .rst_n (rst_s_n),
    .run   (dsp_clk_en_i),
    .limit (dsp_dly_i),
    .done  (dsp_done)
  );

  rrs_delay_cnt #(.W(CARD_W), .CLR_ON_IDLE(1'b1)) u_card_cnt (
    .clk   (clk),
    .rst_n (rst_s_n),
    .run   (card_clk_on_i),
    .limit (CARD_LIM),
    .done  (card_done)
  );

  assign clk_run_o    = rst_s_n;
  assign mcu_rst_n_o  = mcu_done;
  assign rfi_rst_n_o  = mcu_done;
  assign dsp_rst_n_o  = dsp_done;
  assign card_rst_n_o = card_done;

  // R1: no downstream reset is released before the clocks are started
  assert_hold_until_run_R1: assert property (@(posedge clk) disable iff (!por_n)
    !clk_run_o |-> (!mcu_rst_n_o && !dsp_rst_n_o && !card_rst_n_o));

  // R3: the processor pair is released only after the clock-run strobe was up
  assert_mcu_after_run_R3: assert property (@(posedge clk) disable iff (!por_n)
    $rose(mcu_rst_n_o) |-> $past(clk_run_o));
endmodule

// File: tb/rst_release_seq_tb.sv
module rst_release_seq_tb;
  logic       clk;
  logic       por_n;
  logic       dsp_en;
  logic       card_on;
  logic [7:0] dly;
  logic       clk_run, mcu_n, rfi_n, dsp_n, card_n;

  int n_tests;
  int n_fail;
  bit finished;

  rst_release_seq u_dut (
    .clk           (clk),
    .por_n         (por_n),
    .dsp_clk_en_i  (dsp_en),
    .card_clk_on_i (card_on),
    .dsp_dly_i     (dly),
    .clk_run_o     (clk_run),
    .mcu_rst_n_o   (mcu_n),
    .rfi_rst_n_o   (rfi_n),
    .dsp_rst_n_o   (dsp_n),
    .card_rst_n_o  (card_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // edge index, counted from edge k, at which the processor reset goes high
  function automatic int dsp_release_edge(int n);
    return n;
  endfunction

  // edges that must pass after clk_run_o rises before the processor pair is freed
  function automatic int mcu_release_gap();
    return 256;
  endfunction

  // edge index, counted from edge c, at which the card reset goes high
  function automatic int card_release_edge();
    return 400 * 4 - 1;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // start from reset, release por_n on a falling edge, and wait until clk_run_o is high
  task automatic fresh_start();
    @(negedge clk);
    por_n = 1'b0;
    dsp_en = 1'b0;
    card_on = 1'b0;
    edges(2);
    por_n = 1'b1;
    edges(2);
  endtask

  task automatic dsp_trial(input int n, input string req);
    fresh_start();
    dly = 8'(n);
    dsp_en = 1'b1;
    if (dsp_release_edge(n) > 0) begin
      edges(dsp_release_edge(n));
      chk(req, dsp_n, 1'b0);
      edges(1);
    end else begin
      edges(1);
    end
    chk(req, dsp_n, 1'b1);
  endtask

  initial begin
    n_tests = 0;
    n_fail = 0;
    finished = 0;
    por_n = 1'b0;
    dsp_en = 1'b0;
    card_on = 1'b0;
    dly = 8'd255;
    void'($urandom(32'd4242));

    // R1 reset state
    edges(3);
    chk("R1 clk_run", clk_run, 1'b0);
    chk("R1 mcu", mcu_n, 1'b0);
    chk("R1 dsp", dsp_n, 1'b0);
    chk("R1 card", card_n, 1'b0);

    // R2 and R3 release timing
    por_n = 1'b1;
    edges(1);
    chk("R2 after e1", clk_run, 1'b0);
    edges(1);
    chk("R2 after e2", clk_run, 1'b1);
    edges(mcu_release_gap() - 1);
    chk("R3 mcu at e257", mcu_n, 1'b0);
    chk("R3 rfi at e257", rfi_n, 1'b0);
    edges(1);
    chk("R3 mcu at e258", mcu_n, 1'b1);
    chk("R3 rfi at e258", rfi_n, 1'b1);

    // R4 directed corner delays, R8 largest delay
    dsp_trial(0, "R4 delay 0");
    dsp_trial(1, "R4 delay 1");
    dsp_trial(255, "R8 delay 255");

    // R4 random delays
    for (int i = 0; i < 10; i++) begin
      dsp_trial(int'($urandom % 256), "R4 random delay");
    end

    // R5 enable dropped before the release
    fresh_start();
    dly = 8'd20;
    dsp_en = 1'b1;
    edges(15);
    dsp_en = 1'b0;
    edges(6);
    chk("R5 held after drop", dsp_n, 1'b0);
    dsp_en = 1'b1;
    edges(20);
    chk("R5 count restarted", dsp_n, 1'b0);
    edges(1);
    chk("R5 released after full count", dsp_n, 1'b1);

    // R7 enable removed after the release
    dsp_en = 1'b0;
    edges(5);
    chk("R7 dsp stays high", dsp_n, 1'b1);

    // R6 card reset timing and restart
    fresh_start();
    card_on = 1'b1;
    edges(card_release_edge());
    chk("R6 card held", card_n, 1'b0);
    edges(1);
    chk("R6 card released", card_n, 1'b1);
    card_on = 1'b0;
    edges(4);
    chk("R7 card stays high", card_n, 1'b1);

    fresh_start();
    card_on = 1'b1;
    edges(1000);
    card_on = 1'b0;
    edges(5);
    card_on = 1'b1;
    edges(card_release_edge());
    chk("R6 card restart held", card_n, 1'b0);
    edges(1);
    chk("R6 card restart released", card_n, 1'b1);

    // R1 asynchronous reassertion with every line released
    dly = 8'd3;
    dsp_en = 1'b1;
    edges(300);
    chk("R1 pre mcu", mcu_n, 1'b1);
    chk("R1 pre dsp", dsp_n, 1'b1);
    #1;
    por_n = 1'b0;
    #0.5;
    chk("R1 async clk_run", clk_run, 1'b0);
    chk("R1 async mcu", mcu_n, 1'b0);
    chk("R1 async rfi", rfi_n, 1'b0);
    chk("R1 async dsp", dsp_n, 1'b0);
    chk("R1 async card", card_n, 1'b0);

    // R1 counts restart after the reassertion
    @(negedge clk);
    por_n = 1'b1;
    edges(2);
    chk("R1 restart clk_run", clk_run, 1'b1);
    edges(3);
    chk("R1 restart dsp held", dsp_n, 1'b0);
    edges(1);
    chk("R1 restart dsp released", dsp_n, 1'b1);
    chk("R1 restart mcu held", mcu_n, 1'b0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule